// File: doc/BRIEF.md
# Scoreboard Issue and Completion Controller

This block decides, every clock cycle, which instruction of a small floating-point pipeline may enter a functional unit, which units may fetch their operands, and which finished units may retire their result to the register file. Instructions arrive in program order on a valid/ready handshake. Each one carries an operation class, a destination register and two source register numbers. Five functional units are tracked: one integer/load unit, one adder, two multipliers and one divider. No unit is pipelined, and each unit's datapath is stood in for by a fixed-latency countdown timer inside the block.

All hazard bookkeeping lives in one place: a record per unit and a register-to-producer map. Each pipeline step stalls on its own kind of hazard. Issue waits out structural and output (write-after-write) conflicts. The operand read waits out true (read-after-write) dependences. Write-back waits out anti (write-after-read) dependences. The block reports every step as a per-unit strobe, tagged with a sequence number for the instruction. A free-running cycle counter lets a trace of issue, read, completion and write cycles be rebuilt at the ports.

Top module: `sb_scoreboard`

## Requirements
- R1: While reset is held, and in the first cycle after it, rd_go, ex_done and wr_go are all zero, cycle_no is 1, and in_ready is high for any class whose destination register is free.
- R2: An instruction is accepted in a cycle where in_valid and in_ready are both high. Accepted instructions get sequence tags 0, 1, 2, … in order, and unit_tag shows the tag held by each busy unit.
- R3: Class codes are 0 integer/load, 1 add, 2 multiply, 3 divide. Units are numbered 0 integer, 1 adder, 2 first multiplier, 3 second multiplier, 4 divider. in_ready is low while no idle unit of the head's class exists. A multiply takes the lower-numbered idle multiplier, and iss_unit names the chosen unit.
- R4: in_ready is low while any active instruction targets the head's destination register. A unit and its destination register become usable for issue in the cycle after its write-back, not in the same cycle.
- R5: A non-integer unit asserts rd_go at the earliest one cycle after issue, and only once every source has no pending producer. A source whose producer writes back in cycle t becomes readable in cycle t+1. The integer class ignores its source fields.
- R6: ex_done of a unit rises exactly L cycles after its rd_go. L is 1 for integer, 2 for add, 10 for multiply and 40 for divide.
- R7: A finished unit is held from writing back while any other non-integer unit that has not yet read its operands names the same register as a source whose ready flag is set.
- R8: A unit writes back at the earliest one cycle after ex_done. At most WR_PORTS units (default 1) are granted per cycle, in unit-number order (integer first, divider last).
- R9: For the six-instruction test sequence, issued from cycle 1, issue/read/done/write happen in cycles (1,2,3,4), (5,6,7,8), (6,9,19,20), (7,9,11,12), (8,21,61,62) and (13,14,16,22). The sequence is: load F6; load F2; mul F0=F2*F4; add-class F8=F6,F2; div F10=F0/F6; add F6=F8+F2.
- R10: cycle_no increases by exactly one every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Head instruction present |
| in_ready | output | 1 | Head instruction can issue this cycle |
| in_cls | input | 2 | Operation class of the head |
| in_dst | input | $clog2(NREG) | Destination register |
| in_src1 | input | $clog2(NREG) | First source register |
| in_src2 | input | $clog2(NREG) | Second source register |
| iss_unit | output | 3 | Unit chosen for the head when it issues |
| rd_go | output | 5 | Per-unit operand-read strobe |
| ex_done | output | 5 | Per-unit execution-complete strobe |
| wr_go | output | 5 | Per-unit write-back grant |
| unit_tag | output | 5*TAGW | Sequence tag held by each unit |
| cycle_no | output | CYCW | Cycle counter, 1 in the first cycle after reset |

## Verification
The assertions assume the head instruction only changes after it has been accepted, and that its fields are stable while in_valid is high. The bench's driver presents the next queued instruction only after a cycle where it saw in_valid and in_ready together. The assertions also assume that the timers are the only source of completion, so that a unit's done strobe follows its read by exactly its latency. The stimulus builds hazards only from register numbers: sequences where one producer feeds two multipliers force a write-port collision, and a pending divide sits in front of a load that names it as a source.

// File: rtl/sb_pkg.sv
// Shared constants and types for the scoreboard controller.
// Assumes a fixed set of five units; the unit number doubles as write priority.
package sb_pkg;
    localparam int NU     = 5;
    localparam int UW     = $clog2(NU);
    localparam int U_INT  = 0;
    localparam int U_ADD  = 1;
    localparam int U_MUL0 = 2;
    localparam int U_MUL1 = 3;
    localparam int U_DIV  = 4;

    typedef enum logic [1:0] {
        CL_INT = 2'd0,
        CL_ADD = 2'd1,
        CL_MUL = 2'd2,
        CL_DIV = 2'd3
    } cls_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RD   = 2'd1,
        PH_EX   = 2'd2,
        PH_WR   = 2'd3
    } phase_e;

    // Class served by a unit number.
    function automatic cls_e unit_cls(input int u);
        case (u)
            U_INT:   return CL_INT;
            U_ADD:   return CL_ADD;
            U_DIV:   return CL_DIV;
            default: return CL_MUL;
        endcase
    endfunction
endpackage

// File: rtl/sb_fu_timer.sv
// Fixed-latency stand-in for a non-pipelined functional unit datapath.
// Assumes start is only pulsed while idle; done pulses LAT cycles after start.
module sb_fu_timer #(
    parameter int LAT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;
    logic          run;

    // Count down from LAT after each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(LAT);
        end else if (run) begin
            if (cnt == CW'(1)) run <= 1'b0;
            cnt <= cnt - 1'b1;
        end
    end

    assign done = run && (cnt == CW'(1));
endmodule

// File: rtl/sb_wb_arbiter.sv
// Fixed-priority grant of register-file write ports; lowest index wins.
// Assumes requests already passed the anti-dependence check.
module sb_wb_arbiter #(
    parameter int N     = 5,
    parameter int PORTS = 1
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Grant the first PORTS requesters in index order.
    always_comb begin
        int taken;
        taken = 0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && taken < PORTS) begin
                gnt[i] = 1'b1;
                taken++;
            end
        end
    end
endmodule

// File: rtl/sb_scoreboard.sv
// Centralized scoreboard: in-order issue, operand-read, completion and
// write-back control for five non-pipelined units. Assumes the head
// instruction holds steady until accepted; no forwarding, no speculation.
module sb_scoreboard
    import sb_pkg::*;
#(
    parameter int NREG     = 32,
    parameter int WR_PORTS = 1,
    parameter int TAGW     = 8,
    parameter int CYCW     = 16,
    parameter int LAT_INT  = 1,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [1:0]               in_cls,
    input  logic [$clog2(NREG)-1:0]  in_dst,
    input  logic [$clog2(NREG)-1:0]  in_src1,
    input  logic [$clog2(NREG)-1:0]  in_src2,
    output logic [UW-1:0]            iss_unit,
    output logic [NU-1:0]            rd_go,
    output logic [NU-1:0]            ex_done,
    output logic [NU-1:0]            wr_go,
    output logic [NU*TAGW-1:0]       unit_tag,
    output logic [CYCW-1:0]          cycle_no
);
    localparam int RW = $clog2(NREG);

    // Per-unit status records.
    phase_e          ph  [NU];
    logic [RW-1:0]   fi  [NU];
    logic [RW-1:0]   fj  [NU];
    logic [RW-1:0]   fk  [NU];
    logic            qjv [NU];
    logic            qkv [NU];
    logic [UW-1:0]   qj  [NU];
    logic [UW-1:0]   qk  [NU];
    logic            rj  [NU];
    logic            rk  [NU];
    logic [TAGW-1:0] tg  [NU];

    // Register-to-producer map.
    logic [NREG-1:0] rsv;
    logic [UW-1:0]   rsu [NREG];

    logic [TAGW-1:0] tag_ctr;
    logic [CYCW-1:0] cyc;
    logic [NU-1:0]   wr_req;
    logic            sel_ok;
    logic [UW-1:0]   sel_u;
    logic            fire;
    logic            int_cls;
    logic            j_rdy, k_rdy;

    // Choose the lowest-numbered idle unit of the head's class.
    always_comb begin
        sel_ok = 1'b0;
        sel_u  = '0;
        for (int u = NU - 1; u >= 0; u--) begin
            if (unit_cls(u) == cls_e'(in_cls) && ph[u] == PH_IDLE) begin
                sel_ok = 1'b1;
                sel_u  = UW'(u);
            end
        end
    end

    assign in_ready = sel_ok && !rsv[in_dst];
    assign fire     = in_valid && in_ready;
    assign iss_unit = sel_u;
    assign int_cls  = (cls_e'(in_cls) == CL_INT);

    // Source readiness at issue: no producer, or producer retiring now.
    assign j_rdy = int_cls || !rsv[in_src1] || wr_go[rsu[in_src1]];
    assign k_rdy = int_cls || !rsv[in_src2] || wr_go[rsu[in_src2]];

    // Operand read once both flags are set.
    always_comb begin
        for (int u = 0; u < NU; u++) rd_go[u] = (ph[u] == PH_RD) && rj[u] && rk[u];
    end

    // Write request: finished and no pending reader of the old value.
    always_comb begin
        for (int u = 0; u < NU; u++) begin
            wr_req[u] = (ph[u] == PH_WR);
            for (int v = 0; v < NU; v++) begin
                if (v != u && unit_cls(v) != CL_INT && ph[v] == PH_RD &&
                    ((fj[v] == fi[u] && rj[v]) || (fk[v] == fi[u] && rk[v])))
                    wr_req[u] = 1'b0;
            end
        end
    end

    sb_wb_arbiter #(.N(NU), .PORTS(WR_PORTS)) u_arb (
        .req (wr_req),
        .gnt (wr_go)
    );

    for (genvar u = 0; u < NU; u++) begin : g_fu
        localparam int L = (u == U_INT) ? LAT_INT :
                           (u == U_ADD) ? LAT_ADD :
                           (u == U_DIV) ? LAT_DIV : LAT_MUL;
        sb_fu_timer #(.LAT(L)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (rd_go[u]),
            .done  (ex_done[u])
        );
        assign unit_tag[u*TAGW +: TAGW] = tg[u];
    end

    // Record updates: phase moves, result broadcast, and issue fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < NU; u++) begin
                ph[u]  <= PH_IDLE;
                fi[u]  <= '0;
                fj[u]  <= '0;
                fk[u]  <= '0;
                qjv[u] <= 1'b0;
                qkv[u] <= 1'b0;
                qj[u]  <= '0;
                qk[u]  <= '0;
                rj[u]  <= 1'b0;
                rk[u]  <= 1'b0;
                tg[u]  <= '0;
            end
        end else begin
            for (int u = 0; u < NU; u++) begin
                if (wr_go[u]) begin
                    ph[u] <= PH_IDLE;
                end else if (rd_go[u]) begin
                    ph[u] <= PH_EX;
                    rj[u] <= 1'b0;
                    rk[u] <= 1'b0;
                end else if (ph[u] == PH_EX && ex_done[u]) begin
                    ph[u] <= PH_WR;
                end
                for (int w = 0; w < NU; w++) begin
                    if (wr_go[w] && qjv[u] && qj[u] == UW'(w)) begin
                        rj[u]  <= 1'b1;
                        qjv[u] <= 1'b0;
                    end
                    if (wr_go[w] && qkv[u] && qk[u] == UW'(w)) begin
                        rk[u]  <= 1'b1;
                        qkv[u] <= 1'b0;
                    end
                end
            end
            if (fire) begin
                ph[sel_u]  <= PH_RD;
                fi[sel_u]  <= in_dst;
                fj[sel_u]  <= in_src1;
                fk[sel_u]  <= in_src2;
                rj[sel_u]  <= j_rdy;
                rk[sel_u]  <= k_rdy;
                qjv[sel_u] <= !j_rdy;
                qkv[sel_u] <= !k_rdy;
                qj[sel_u]  <= rsu[in_src1];
                qk[sel_u]  <= rsu[in_src2];
                tg[sel_u]  <= tag_ctr;
            end
        end
    end

    // Register-result map: clear on write-back, claim on issue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv <= '0;
            for (int r = 0; r < NREG; r++) rsu[r] <= '0;
        end else begin
            for (int w = 0; w < NU; w++) begin
                if (wr_go[w]) rsv[fi[w]] <= 1'b0;
            end
            if (fire) begin
                rsv[in_dst] <= 1'b1;
                rsu[in_dst] <= sel_u;
            end
        end
    end

    // Sequence tag and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_ctr <= '0;
            cyc     <= CYCW'(1);
        end else begin
            cyc <= cyc + 1'b1;
            if (fire) tag_ctr <= tag_ctr + 1'b1;
        end
    end

    assign cycle_no = cyc;
endmodule

// File: rtl/sb_scoreboard_chk.sv
// Property checker for sb_scoreboard, attached by bind.
// Assumes completion comes only from the internal timers.
module sb_scoreboard_chk
    import sb_pkg::*;
#(
    parameter int WR_PORTS = 1,
    parameter int CYCW     = 16,
    parameter int LAT_INT  = 1,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            in_ready,
    input logic [UW-1:0]   iss_unit,
    input logic [NU-1:0]   rd_go,
    input logic [NU-1:0]   ex_done,
    input logic [NU-1:0]   wr_go,
    input logic [CYCW-1:0] cycle_no
);
    a_r8_port_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_go) <= WR_PORTS);

    a_r3_issue_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> !rd_go[iss_unit] && !ex_done[iss_unit] && !wr_go[iss_unit]);

    a_r10_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_no == CYCW'($past(cycle_no) + 1'b1));

    for (genvar u = 0; u < NU; u++) begin : g_u
        localparam int L = (u == U_INT) ? LAT_INT :
                           (u == U_ADD) ? LAT_ADD :
                           (u == U_DIV) ? LAT_DIV : LAT_MUL;
        int   since;
        logic armed;

        // Track cycles elapsed since this unit's operand read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                armed <= 1'b0;
                since <= 0;
            end else if (rd_go[u]) begin
                armed <= 1'b1;
                since <= 1;
            end else if (ex_done[u]) begin
                armed <= 1'b0;
            end else if (armed) begin
                since <= since + 1;
            end
        end

        a_r6_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
            ex_done[u] |-> armed && since == L);

        a_r6_no_late_done: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && since == L) |-> ex_done[u]);

        a_r8_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
            ex_done[u] |-> !wr_go[u]);

        a_r4_write_frees: assert property (@(posedge clk) disable iff (!rst_n)
            wr_go[u] |=> !wr_go[u] && !rd_go[u]);
    end
endmodule

bind sb_scoreboard sb_scoreboard_chk #(
    .WR_PORTS (WR_PORTS),
    .CYCW     (CYCW),
    .LAT_INT  (LAT_INT),
    .LAT_ADD  (LAT_ADD),
    .LAT_MUL  (LAT_MUL),
    .LAT_DIV  (LAT_DIV)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .iss_unit (iss_unit),
    .rd_go    (rd_go),
    .ex_done  (ex_done),
    .wr_go    (wr_go),
    .cycle_no (cycle_no)
);

// File: tb/tb_sb_scoreboard.sv
`timescale 1ns/1ps
module tb_sb_scoreboard;
    localparam int NU   = 5;
    localparam int TAGW = 8;
    localparam int CYCW = 16;
    localparam int NT   = 64;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                in_valid;
    logic                in_ready;
    logic [1:0]          in_cls;
    logic [4:0]          in_dst, in_src1, in_src2;
    logic [2:0]          iss_unit;
    logic [NU-1:0]       rd_go, ex_done, wr_go;
    logic [NU*TAGW-1:0]  unit_tag;
    logic [CYCW-1:0]     cycle_no;

    always #2.5 clk = ~clk;

    sb_scoreboard dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
        .iss_unit(iss_unit), .rd_go(rd_go), .ex_done(ex_done), .wr_go(wr_go),
        .unit_tag(unit_tag), .cycle_no(cycle_no)
    );

    int checks = 0;
    int errors = 0;

    typedef struct { int cls; int dst; int s1; int s2; } ins_t;
    ins_t q[$];

    // Reference model state.
    int m_ph[NU], m_cnt[NU], m_fi[NU], m_fj[NU], m_fk[NU];
    int m_qj[NU], m_qk[NU], m_rj[NU], m_rk[NU], m_tag[NU];
    int m_rs[32];
    int m_tagc, m_cyc;
    int t_iss[NT], t_rd[NT], t_done[NT], t_wr[NT];

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic int ucls(input int u);
        if (u == 0) return 0;
        if (u == 1) return 1;
        if (u == 4) return 3;
        return 2;
    endfunction

    function automatic int lat(input int u);
        case (ucls(u))
            0: return 1;
            1: return 2;
            2: return 10;
            default: return 40;
        endcase
    endfunction

    task automatic model_reset();
        for (int u = 0; u < NU; u++) begin
            m_ph[u] = 0; m_cnt[u] = 0; m_qj[u] = -1; m_qk[u] = -1;
            m_rj[u] = 0; m_rk[u] = 0; m_tag[u] = 0;
            m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
        end
        for (int r = 0; r < 32; r++) m_rs[r] = -1;
        m_tagc = 0;
        m_cyc  = 1;
    endtask

    function automatic int dtag(input int u);
        return int'(unit_tag[u*TAGW +: TAGW]);
    endfunction

    // One cycle of the reference model: predict, compare, advance.
    task automatic step();
        bit e_rd[NU], e_done[NU], e_wr[NU], req[NU];
        int taken, sel, pj, pk, rjn, rkn;
        bit e_ready, fire;
        for (int u = 0; u < NU; u++) begin
            e_rd[u]   = (m_ph[u] == 1) && m_rj[u] != 0 && m_rk[u] != 0;
            e_done[u] = (m_ph[u] == 2) && m_cnt[u] == 1;
            req[u]    = (m_ph[u] == 3);
            for (int v = 0; v < NU; v++)
                if (v != u && ucls(v) != 0 && m_ph[v] == 1 &&
                    ((m_fj[v] == m_fi[u] && m_rj[v] != 0) || (m_fk[v] == m_fi[u] && m_rk[v] != 0)))
                    req[u] = 0;
        end
        taken = 0;
        for (int u = 0; u < NU; u++) begin
            e_wr[u] = req[u] && taken < 1;
            if (e_wr[u]) taken++;
        end
        sel = -1;
        for (int u = 0; u < NU; u++)
            if (sel < 0 && ucls(u) == int'(in_cls) && m_ph[u] == 0) sel = u;
        e_ready = (sel >= 0) && m_rs[in_dst] < 0;
        fire    = in_valid && e_ready;

        chk(in_ready == e_ready, "R4 in_ready", int'(in_ready), int'(e_ready));
        chk(int'(cycle_no) == m_cyc, "R10 cycle_no", int'(cycle_no), m_cyc);
        if (fire) chk(int'(iss_unit) == sel, "R3 iss_unit", int'(iss_unit), sel);
        for (int u = 0; u < NU; u++) begin
            chk(rd_go[u] == e_rd[u], $sformatf("R5 rd_go[%0d] cyc %0d", u, m_cyc), int'(rd_go[u]), int'(e_rd[u]));
            chk(ex_done[u] == e_done[u], $sformatf("R6 ex_done[%0d] cyc %0d", u, m_cyc), int'(ex_done[u]), int'(e_done[u]));
            chk(wr_go[u] == e_wr[u], $sformatf("R8 wr_go[%0d] cyc %0d", u, m_cyc), int'(wr_go[u]), int'(e_wr[u]));
            if (m_ph[u] != 0) chk(dtag(u) == m_tag[u], $sformatf("R2 unit_tag[%0d]", u), dtag(u), m_tag[u]);
            if (rd_go[u] && dtag(u) < NT)   t_rd[dtag(u)]   = m_cyc;
            if (ex_done[u] && dtag(u) < NT) t_done[dtag(u)] = m_cyc;
            if (wr_go[u] && dtag(u) < NT)   t_wr[dtag(u)]   = m_cyc;
        end

        // Issue fields from the pre-edge map.
        pj = m_rs[in_src1];
        pk = m_rs[in_src2];
        rjn = (in_cls == 2'd0 || pj < 0 || (pj >= 0 && e_wr[pj])) ? 1 : 0;
        rkn = (in_cls == 2'd0 || pk < 0 || (pk >= 0 && e_wr[pk])) ? 1 : 0;

        for (int u = 0; u < NU; u++) begin
            if (e_wr[u]) begin
                m_ph[u] = 0;
                m_rs[m_fi[u]] = -1;
                for (int v = 0; v < NU; v++) begin
                    if (m_qj[v] == u) begin m_rj[v] = 1; m_qj[v] = -1; end
                    if (m_qk[v] == u) begin m_rk[v] = 1; m_qk[v] = -1; end
                end
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (e_rd[u]) begin
                m_ph[u] = 2; m_cnt[u] = lat(u); m_rj[u] = 0; m_rk[u] = 0;
            end else if (m_ph[u] == 2) begin
                if (m_cnt[u] == 1) m_ph[u] = 3;
                else m_cnt[u]--;
            end
        end
        if (fire) begin
            m_ph[sel] = 1;
            m_fi[sel] = int'(in_dst); m_fj[sel] = int'(in_src1); m_fk[sel] = int'(in_src2);
            m_rj[sel] = rjn; m_rk[sel] = rkn;
            m_qj[sel] = rjn != 0 ? -1 : pj;
            m_qk[sel] = rkn != 0 ? -1 : pk;
            m_tag[sel] = m_tagc;
            if (m_tagc < NT) t_iss[m_tagc] = m_cyc;
            m_rs[in_dst] = sel;
            m_tagc++;
            void'(q.pop_front());
        end
        m_cyc++;
    endtask

    task automatic drive();
        if (q.size() > 0) begin
            in_valid = 1'b1;
            in_cls  = 2'(q[0].cls);
            in_dst  = 5'(q[0].dst);
            in_src1 = 5'(q[0].s1);
            in_src2 = 5'(q[0].s2);
        end else begin
            in_valid = 1'b0; in_cls = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
        end
    endtask

    function automatic bit idle();
        if (q.size() > 0) return 0;
        for (int u = 0; u < NU; u++) if (m_ph[u] != 0) return 0;
        return 1;
    endfunction

    task automatic run_idle();
        do begin
            @(negedge clk);
            drive();
            #1;
            step();
        end while (!idle());
        @(negedge clk); drive(); #1; step();
    endtask

    task automatic push(input int c, input int d, input int a, input int b);
        ins_t i;
        i.cls = c; i.dst = d; i.s1 = a; i.s2 = b;
        q.push_back(i);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int exp_t[6][4];
        exp_t = '{'{1,2,3,4}, '{5,6,7,8}, '{6,9,19,20}, '{7,9,11,12}, '{8,21,61,62}, '{13,14,16,22}};
        rst_n = 1'b0;
        in_valid = 1'b0; in_cls = '0; in_dst = '0; in_src1 = '0; in_src2 = '0;
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state.
        chk(rd_go == '0 && ex_done == '0 && wr_go == '0, "R1 strobes in reset", int'({rd_go, ex_done, wr_go}), 0);
        chk(int'(cycle_no) == 1, "R1 cycle_no in reset", int'(cycle_no), 1);
        chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);

        // Six-instruction sequence with RAW, WAR and WAW dependences (R9).
        push(0, 6, 2, 2);
        push(0, 2, 3, 3);
        push(2, 0, 2, 4);
        push(1, 8, 6, 2);
        push(3, 10, 0, 6);
        push(1, 6, 8, 2);
        @(negedge clk);
        rst_n = 1'b1;
        drive();
        #1;
        step();
        run_idle();
        for (int t = 0; t < 6; t++) begin
            chk(t_iss[t]  == exp_t[t][0], $sformatf("R9 issue tag %0d", t), t_iss[t], exp_t[t][0]);
            chk(t_rd[t]   == exp_t[t][1], $sformatf("R9 read tag %0d", t), t_rd[t], exp_t[t][1]);
            chk(t_done[t] == exp_t[t][2], $sformatf("R9 done tag %0d", t), t_done[t], exp_t[t][2]);
            chk(t_wr[t]   == exp_t[t][3], $sformatf("R9 write tag %0d", t), t_wr[t], exp_t[t][3]);
        end
        chk(t_wr[5] == t_rd[4] + 1, "R7 write held until pending read", t_wr[5], t_rd[4] + 1);

        // One load feeding both multipliers: same-cycle finish, priority (R8).
        push(0, 9, 0, 0);
        push(2, 10, 9, 1);
        push(2, 11, 9, 2);
        run_idle();
        chk(t_rd[7] == t_wr[6] + 1, "R5 read after producer write", t_rd[7], t_wr[6] + 1);
        chk(t_done[8] == t_done[7], "R8 both multipliers finish together", t_done[8], t_done[7]);
        chk(t_wr[8] == t_wr[7] + 1, "R8 lower unit writes first", t_wr[8], t_wr[7] + 1);

        // Output dependence across units (R4).
        push(2, 12, 1, 2);
        push(3, 12, 3, 4);
        run_idle();
        chk(t_iss[10] == t_wr[9] + 1, "R4 issue after same-dest write", t_iss[10], t_wr[9] + 1);

        // Integer class ignores pending sources; add waits (R5, R6).
        push(3, 14, 1, 2);
        push(0, 15, 14, 14);
        push(1, 16, 14, 1);
        run_idle();
        chk(t_rd[12] == t_iss[12] + 1, "R5 integer ignores sources", t_rd[12], t_iss[12] + 1);
        chk(t_rd[13] == t_wr[11] + 1, "R5 add waits for divide", t_rd[13], t_wr[11] + 1);
        chk(t_done[11] - t_rd[11] == 40, "R6 divide latency", t_done[11] - t_rd[11], 40);
        chk(t_done[13] - t_rd[13] == 2, "R6 add latency", t_done[13] - t_rd[13], 2);
        chk(t_iss[12] == t_iss[11] + 1, "R2 in-order acceptance", t_iss[12], t_iss[11] + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule